// File: doc/BRIEF.md
# Accumulator ALU with Carry and Overflow Flags

This block is the arithmetic and logic stage of a small accumulator CPU. Each cycle it takes the current accumulator value, an 8-bit operand fetched from data memory and a 3-bit operation select. It returns the new accumulator value combinationally, so the surrounding datapath can load it into the accumulator at the next clock edge.

Beside the result it keeps a two-bit flag register that holds a carry flag and an overflow flag. The flags are registered and persist across instructions, so a later conditional jump can test them. The flags change only on a clock edge where the enable is high and the selected operation defines that flag. Operations that do not define a flag leave it as it was. Instruction decoding, memory access and the accumulator register itself belong to the surrounding CPU.

Top module: `accu_alu_flags`

## Requirements
- R1: Add (op=3'd1) returns (acc_in + opnd_in) mod 256. When enabled, it loads carry with the unsigned carry out of bit 7. It loads overflow high when both inputs have the same sign bit and the result's sign bit differs from it.
- R2: AND (op=3'd2) returns acc_in & opnd_in bitwise, and it leaves both flags unchanged.
- R3: Increment (op=3'd3) returns acc_in + 1 mod 256. When enabled, it sets overflow high exactly when acc_in is 8'h7F and low otherwise, and it leaves carry unchanged.
- R4: Decrement (op=3'd4) returns acc_in - 1 mod 256. When enabled, it sets overflow high exactly when acc_in is 8'h80 and low otherwise, and it leaves carry unchanged.
- R5: Shift left (op=3'd5) returns {acc_in[6:0],0}. When enabled, it loads carry with acc_in[7], and it leaves overflow unchanged.
- R6: Shift right (op=3'd6) is a logical shift that returns {0,acc_in[7:1]}, so bit 7 of the result is always 0. When enabled, it loads carry with acc_in[0], and it leaves overflow unchanged.
- R7: Invert (op=3'd7) returns ~acc_in, and it leaves both flags unchanged.
- R8: Pass-through (op=3'd0) returns opnd_in unchanged, and it leaves both flags unchanged.
- R9: While en is low, both flags hold their values at every clock edge, whatever the operation. The result output still reflects the selected operation.
- R10: A low rst_n sampled at a clock edge clears both flags, and this takes priority over en. Outside reset, the flags keep their values across any number of cycles until an enabled operation defines them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset of the flag register |
| en | input | 1 | Allows the flags to update at this edge |
| op | input | 3 | Operation select: 0 pass, 1 add, 2 AND, 3 increment, 4 decrement, 5 shift left, 6 shift right, 7 invert |
| acc_in | input | 8 | Current accumulator value |
| opnd_in | input | 8 | Memory operand |
| acc_out | output | 8 | New accumulator value (combinational) |
| carry_o | output | 1 | Registered carry flag |
| ovf_o | output | 1 | Registered overflow flag |

## Verification
The bench drives increment at 8'h7F and 8'hFF and decrement at 8'h80 and 8'h00. These catch a design that reports unsigned wrap as overflow, or one that disturbs carry on increment and decrement. It adds values whose signs match and differ, around the 127/128 and 255/0 boundaries. These expose a design that confuses carry with signed overflow. It shifts values with 1s in bit 7 and bit 0, which reveals an arithmetic right shift or a carry taken from the wrong end. Random operations with en toggling, together with a reset asserted while en is high, catch flags that update when disabled, flags changed by AND, invert or pass-through, and a reset that loses priority.

// File: rtl/alu_pkg.sv
// Shared types for the accumulator ALU: the operation encoding and the
// flag register layout. Assumes a 3-bit operation select.
package alu_pkg;
    typedef enum logic [2:0] {
        OP_PASS = 3'd0,
        OP_ADD  = 3'd1,
        OP_AND  = 3'd2,
        OP_INC  = 3'd3,
        OP_DEC  = 3'd4,
        OP_SHL  = 3'd5,
        OP_SHR  = 3'd6,
        OP_INV  = 3'd7
    } op_e;

    localparam int FLAG_N = 2;
    localparam int FLAG_C = 0;   // carry bit index
    localparam int FLAG_V = 1;   // overflow bit index
endpackage

// File: rtl/alu_datapath.sv
// Combinational ALU core. It computes the result, the candidate flag values
// and a per-flag update mask for the selected operation.
// Assumes W >= 2. Signed views use two's complement.
module alu_datapath #(
    parameter int W = 8
) (
    input  alu_pkg::op_e                 op,
    input  logic [W-1:0]                 a,
    input  logic [W-1:0]                 b,
    output logic [W-1:0]                 res,
    output logic [alu_pkg::FLAG_N-1:0]   flag_nx,
    output logic [alu_pkg::FLAG_N-1:0]   flag_upd
);
    import alu_pkg::*;

    localparam int MSB = W - 1;
    localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

    logic [W:0] sum;

    // Purpose: select the result and the flag candidates for each operation.
    always_comb begin
        sum      = {1'b0, a} + {1'b0, b};
        res      = b;
        flag_nx  = '0;
        flag_upd = '0;
        unique case (op)
            OP_PASS: res = b;
            OP_ADD: begin
                res              = sum[W-1:0];
                flag_nx[FLAG_C]  = sum[W];
                flag_nx[FLAG_V]  = (a[MSB] == b[MSB]) && (sum[MSB] != a[MSB]);
                flag_upd         = '1;
            end
            OP_AND: res = a & b;
            OP_INC: begin
                res              = a + ONE;
                flag_nx[FLAG_V]  = (a == SMAX);
                flag_upd[FLAG_V] = 1'b1;
            end
            OP_DEC: begin
                res              = a - ONE;
                flag_nx[FLAG_V]  = (a == SMIN);
                flag_upd[FLAG_V] = 1'b1;
            end
            OP_SHL: begin
                res              = {a[MSB-1:0], 1'b0};
                flag_nx[FLAG_C]  = a[MSB];
                flag_upd[FLAG_C] = 1'b1;
            end
            OP_SHR: begin
                res              = {1'b0, a[MSB:1]};
                flag_nx[FLAG_C]  = a[0];
                flag_upd[FLAG_C] = 1'b1;
            end
            OP_INV: res = ~a;
            default: res = b;
        endcase
    end
endmodule

// File: rtl/alu_flag_reg.sv
// Flag register. Each bit loads its candidate only when the enable and its
// own update bit are both high. Synchronous active-low reset clears all bits.
module alu_flag_reg #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [N-1:0] d,
    input  logic [N-1:0] upd,
    output logic [N-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        // Purpose: hold flag bit i and load it when enabled and selected.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q[i] <= 1'b0;
            else if (en && upd[i])
                q[i] <= d[i];
        end
    end
endmodule

// File: rtl/accu_alu_flags.sv
// Top of the accumulator ALU. It joins the combinational core to the
// two-bit flag register. The caller registers acc_out into its accumulator.
module accu_alu_flags #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [2:0]   op,
    input  logic [W-1:0] acc_in,
    input  logic [W-1:0] opnd_in,
    output logic [W-1:0] acc_out,
    output logic         carry_o,
    output logic         ovf_o
);
    import alu_pkg::*;

    logic [FLAG_N-1:0] flag_nx;
    logic [FLAG_N-1:0] flag_upd;
    logic [FLAG_N-1:0] flag_q;

    alu_datapath #(.W(W)) i_core (
        .op       (op_e'(op)),
        .a        (acc_in),
        .b        (opnd_in),
        .res      (acc_out),
        .flag_nx  (flag_nx),
        .flag_upd (flag_upd)
    );

    alu_flag_reg #(.N(FLAG_N)) i_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .d     (flag_nx),
        .upd   (flag_upd),
        .q     (flag_q)
    );

    assign carry_o = flag_q[FLAG_C];
    assign ovf_o   = flag_q[FLAG_V];
endmodule

// File: rtl/accu_alu_chk.sv
// Property checker for accu_alu_flags. It observes the top ports only and
// is attached by the bind below.
module accu_alu_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         en,
    input logic [2:0]   op,
    input logic [W-1:0] acc_in,
    input logic [W-1:0] opnd_in,
    input logic [W-1:0] acc_out,
    input logic         carry_o,
    input logic         ovf_o
);
    import alu_pkg::*;

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!carry_o && !ovf_o));

    // R9
    hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(carry_o) && $stable(ovf_o)));

    // R2 R7 R8
    flagless_ops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && (op == OP_AND || op == OP_INV || op == OP_PASS))
        |=> ($stable(carry_o) && $stable(ovf_o)));

    // R3 R4
    incdec_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && (op == OP_INC || op == OP_DEC)) |=> $stable(carry_o));

    // R5
    shl_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && op == OP_SHL) |=> (carry_o == $past(acc_in[W-1]) && $stable(ovf_o)));

    // R6
    shr_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && op == OP_SHR) |=> (carry_o == $past(acc_in[0]) && $stable(ovf_o)));

    // R6
    shr_zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_SHR) |-> !acc_out[W-1]);

    // R3
    inc_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && op == OP_INC) |=> (ovf_o == ($past(acc_in) == {1'b0, {(W-1){1'b1}}})));
endmodule

bind accu_alu_flags accu_alu_chk #(.W(W)) i_chk (
    .clk(clk), .rst_n(rst_n), .en(en), .op(op), .acc_in(acc_in),
    .opnd_in(opnd_in), .acc_out(acc_out), .carry_o(carry_o), .ovf_o(ovf_o)
);

// File: tb/test_accu_alu_flags.sv
module test_accu_alu_flags;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [2:0] op = 3'd0;
    logic [7:0] acc_in = 8'd0;
    logic [7:0] opnd_in = 8'd0;
    logic [7:0] acc_out;
    logic       carry_o, ovf_o;

    int errors = 0;
    int checks = 0;
    logic ref_c = 1'b0;
    logic ref_v = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    accu_alu_flags i_accu_alu_flags (
        .clk(clk), .rst_n(rst_n), .en(en), .op(op), .acc_in(acc_in),
        .opnd_in(opnd_in), .acc_out(acc_out), .carry_o(carry_o), .ovf_o(ovf_o)
    );

    function automatic string req_of(input logic [2:0] o);
        case (o)
            3'd0: return "R8";
            3'd1: return "R1";
            3'd2: return "R2";
            3'd3: return "R3";
            3'd4: return "R4";
            3'd5: return "R5";
            3'd6: return "R6";
            default: return "R7";
        endcase
    endfunction

    // Expected {result, carry, overflow} from the requirements.
    function automatic logic [9:0] model(input logic [2:0] o, input logic [7:0] a,
                                         input logic [7:0] b, input logic c, input logic v);
        logic [8:0] s;
        case (o)
            3'd0: return {b, c, v};
            3'd1: begin
                s = a + b;
                return {s[7:0], s[8], (a[7] == b[7]) && (s[7] != a[7])};
            end
            3'd2: return {a & b, c, v};
            3'd3: return {a + 8'd1, c, a == 8'h7F};
            3'd4: return {a - 8'd1, c, a == 8'h80};
            3'd5: return {a[6:0], 1'b0, a[7], v};
            3'd6: return {1'b0, a[7:1], a[0], v};
            default: return {~a, c, v};
        endcase
    endfunction

    task automatic check(input string rq, input string what, input logic [7:0] act,
                         input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    // Called at a negedge: drive, check result, clock, check flags.
    task automatic run(input logic [2:0] o, input logic [7:0] a, input logic [7:0] b,
                       input logic e, input string rq);
        logic [9:0] m;
        op = o; acc_in = a; opnd_in = b; en = e;
        m = model(o, a, b, ref_c, ref_v);
        #1;
        check(rq, "result", acc_out, m[9:2]);
        if (e) begin
            ref_c = m[1];
            ref_v = m[0];
        end
        @(posedge clk); #1;
        check(rq, "flags", {6'd0, carry_o, ovf_o}, {6'd0, ref_c, ref_v});
        @(negedge clk);
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd5150));
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R10", "reset flags", {6'd0, carry_o, ovf_o}, 8'd0);
        // R1 corners: signed overflow, unsigned carry, both, none
        run(3'd1, 8'h7F, 8'h01, 1'b1, "R1");
        run(3'd1, 8'hFF, 8'h01, 1'b1, "R1");
        run(3'd1, 8'h80, 8'h80, 1'b1, "R1");
        run(3'd1, 8'h10, 8'h22, 1'b1, "R1");
        // R3 / R4 boundaries, carry preserved
        run(3'd1, 8'hF0, 8'h20, 1'b1, "R1");       // carry=1
        run(3'd3, 8'h7F, 8'h00, 1'b1, "R3");
        run(3'd3, 8'hFF, 8'h00, 1'b1, "R3");
        run(3'd4, 8'h80, 8'h00, 1'b1, "R4");
        run(3'd4, 8'h00, 8'h00, 1'b1, "R4");
        // R5 / R6 carry from each end, overflow kept
        run(3'd3, 8'h7F, 8'h00, 1'b1, "R3");       // overflow=1
        run(3'd5, 8'h81, 8'h00, 1'b1, "R5");
        run(3'd5, 8'h40, 8'h00, 1'b1, "R5");
        run(3'd6, 8'h81, 8'h00, 1'b1, "R6");
        run(3'd6, 8'hFE, 8'h00, 1'b1, "R6");
        // R2 / R7 / R8 flags untouched
        run(3'd2, 8'hF0, 8'h3C, 1'b1, "R2");
        run(3'd7, 8'hA5, 8'h00, 1'b1, "R7");
        run(3'd0, 8'h11, 8'h5A, 1'b1, "R8");
        // R9 disabled ops that would change flags
        run(3'd1, 8'hFF, 8'hFF, 1'b0, "R9");
        run(3'd5, 8'h00, 8'h00, 1'b0, "R9");
        // R10 persistence over idle cycles
        repeat (5) @(negedge clk);
        #1;
        check("R10", "hold", {6'd0, carry_o, ovf_o}, {6'd0, ref_c, ref_v});
        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [2:0] o;
            o = 3'($urandom);
            run(o, 8'($urandom), 8'($urandom), ($urandom % 4) != 0, req_of(o));
        end
        // R10 reset with enable high
        run(3'd1, 8'hC0, 8'hC0, 1'b1, "R1");        // carry=1 overflow=0
        run(3'd3, 8'h7F, 8'h00, 1'b1, "R3");        // overflow=1
        rst_n = 1'b0; op = 3'd1; acc_in = 8'hFF; opnd_in = 8'hFF; en = 1'b1;
        @(posedge clk); #1;
        ref_c = 1'b0; ref_v = 1'b0;
        check("R10", "reset with en", {6'd0, carry_o, ovf_o}, 8'd0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule